// File: doc/BRIEF.md
# Serial-to-Parallel Port Bridge with DAC Code Bank

This block is a write/read slave on a two-wire serial bus. It answers a 7-bit device address whose top four bits are fixed at `1001` and whose low three bits come from strap pins. It bridges the bus to an 8-bit bidirectional parallel port and also holds a small bank of 8-bit DAC code registers. The most significant strap bit also sets how the port and the bank are split. When it is 0 the block has four DAC channels and a full 8-bit port. When it is 1 the block has eight DAC channels and only the low four port bits are live.

A write transaction carries a selector byte after the address. The low nibble of that byte either names one DAC channel or, with the code `1111`, opens a port stream. In a port stream every later byte is driven onto the port. A read transaction has no selector byte. The slave returns one port sample per byte for as long as the master keeps acknowledging. The bus lines reach the block already synchronised to the system clock. The block drives the data line only through a pull-down enable.

Top module: `i2cx_expander`

## Requirements
- R1: A transaction is served only when its 7-bit address equals `1001` followed by strap bits [2:0]. The slave pulls SDA low in the ACK slot of a matching address and of every byte written after it. A non-matching address gets no ACK, and the bytes that follow it change no output.
- R2: After a write whose selector low nibble k lies in 1..4 (strap bit 2 = 0) or 1..8 (strap bit 2 = 1), the next data byte is loaded into DAC channel k. The selector's upper nibble is ignored. Channel k is held at bits [8k-1 : 8k-8] of `dac_code_o`.
- R3: A selector nibble that is 0000 or above the configured channel count, and is not 1111, leaves every DAC register and the port unchanged.
- R4: After a DAC selection, only the first data byte is applied. Later bytes in the same transaction are acknowledged and discarded.
- R5: A selector nibble of 1111 starts a port stream. Each following byte appears on `port_out_o` when its ACK begins, that is at the SCL fall after its eighth bit, and `port_oe_o` goes to all ones. DAC registers are untouched.
- R6: With strap bit 2 = 1, the port bits [7:4] written by a stream are driven as 0, and `port_oe_o` becomes `8'h0F`.
- R7: A read returns one byte per transfer, MSB first. The port is sampled when the byte begins. With strap bit 2 = 1, the upper four returned bits are 0.
- R8: A read continues while the master ACKs. After a NACK the slave releases SDA and drives nothing until the next START.
- R9: A matching read address sets `port_oe_o` to 0 at its ACK. The port stays floated through DAC writes until the ACK of the next port stream byte.
- R10: A START or STOP ends a port stream. After a repeated START, a new selector byte is required before any data is applied.
- R11: After reset, SDA is released, `port_oe_o` and `port_out_o` are 0, and every DAC register holds `8'h00`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line, already synchronised to clk |
| sda_i | input | 1 | Serial data line level, already synchronised to clk |
| strap_i | input | 3 | Low address bits; bit 2 also selects the channel/port split |
| port_in_i | input | 8 | Parallel port input levels |
| sda_pull_o | output | 1 | 1 = pull the data line low |
| port_out_o | output | 8 | Parallel port output data |
| port_oe_o | output | 8 | Per-bit output enable of the parallel port |
| dac_code_o | output | 64 | Eight 8-bit DAC codes; channel 1 in the low byte |

## Verification
An SCL edge is seen one clock after it reaches the pins. The SDA pull-down changes in that same clock. Port and DAC registers change one clock later again, so two clocks after the SCL fall that starts the ACK. The bench changes bus levels only on falling clock edges and then holds each bus phase for four clocks before it samples anything. Every check therefore lands after the result is due and before the next edge can move it. Port values are captured just before and just after the eighth-bit fall, which pins each update to the ACK.

// File: rtl/i2cx_pkg.sv
package i2cx_pkg;

   // byte-level phase of the serial link
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_CHAN,
      ST_WDATA,
      ST_RDATA
   } link_st_e;

   // where data bytes of the current write go
   typedef enum logic [1:0] {
      TGT_NONE,
      TGT_DAC,
      TGT_PORT
   } wr_tgt_e;

   localparam int BYTE_W   = 8;
   localparam int BITCNT_W = 4;
   localparam logic [3:0] SEL_STREAM = 4'hF;

endpackage

// File: rtl/i2cx_line_mon.sv
module i2cx_line_mon (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_i;
         sda_q <= sda_i;
      end
   end

   assign scl_rise  = scl_i & ~scl_q;
   assign scl_fall  = ~scl_i & scl_q;
   assign start_det = scl_i & scl_q & sda_q & ~sda_i;
   assign stop_det  = scl_i & scl_q & ~sda_q & sda_i;

endmodule

// File: rtl/i2cx_link.sv
module i2cx_link
   import i2cx_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic              sda_i,
   input  logic [6:0]        dev_addr,
   input  logic [BYTE_W-1:0] rd_sample,
   output logic              sda_pull,
   output logic              chan_ev,
   output logic              data_ev,
   output logic              read_begin,
   output logic              xfer_end,
   output logic [BYTE_W-1:0] byte_val
);

   link_st_e              st_q;
   logic [BITCNT_W-1:0]   bitcnt_q;
   logic [BYTE_W-1:0]     shreg_q;
   logic [BYTE_W-2:0]     txreg_q;
   logic                  pull_q;
   logic                  mack_q;
   logic                  rw_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         bitcnt_q   <= '0;
         shreg_q    <= '0;
         txreg_q    <= '0;
         pull_q     <= 1'b0;
         mack_q     <= 1'b0;
         rw_q       <= 1'b0;
         chan_ev    <= 1'b0;
         data_ev    <= 1'b0;
         read_begin <= 1'b0;
         xfer_end   <= 1'b0;
         byte_val   <= '0;
      end else begin
         chan_ev    <= 1'b0;
         data_ev    <= 1'b0;
         read_begin <= 1'b0;
         xfer_end   <= 1'b0;
         if (start_det) begin
            st_q     <= ST_ADDR;
            bitcnt_q <= '0;
            pull_q   <= 1'b0;
            xfer_end <= 1'b1;
         end else if (stop_det) begin
            st_q     <= ST_IDLE;
            pull_q   <= 1'b0;
            xfer_end <= 1'b1;
         end else if (st_q != ST_IDLE) begin
            if (scl_rise) begin
               if (bitcnt_q < BITCNT_W'(8))
                  shreg_q <= {shreg_q[BYTE_W-2:0], sda_i};
               if (bitcnt_q < BITCNT_W'(9))
                  bitcnt_q <= bitcnt_q + BITCNT_W'(1);
               if (st_q == ST_RDATA && bitcnt_q == BITCNT_W'(8))
                  mack_q <= ~sda_i;
            end else if (scl_fall) begin
               if (bitcnt_q == BITCNT_W'(8)) begin
                  // start of the acknowledge slot
                  unique case (st_q)
                     ST_ADDR: begin
                        if (shreg_q[7:1] == dev_addr) begin
                           rw_q       <= shreg_q[0];
                           pull_q     <= 1'b1;
                           read_begin <= shreg_q[0];
                        end else begin
                           st_q <= ST_IDLE;
                        end
                     end
                     ST_CHAN: begin
                        pull_q   <= 1'b1;
                        chan_ev  <= 1'b1;
                        byte_val <= shreg_q;
                     end
                     ST_WDATA: begin
                        pull_q   <= 1'b1;
                        data_ev  <= 1'b1;
                        byte_val <= shreg_q;
                     end
                     default: pull_q <= 1'b0;
                  endcase
               end else if (bitcnt_q == BITCNT_W'(9)) begin
                  // end of the acknowledge slot
                  bitcnt_q <= '0;
                  unique case (st_q)
                     ST_ADDR: begin
                        if (rw_q) begin
                           st_q    <= ST_RDATA;
                           txreg_q <= rd_sample[BYTE_W-2:0];
                           pull_q  <= ~rd_sample[BYTE_W-1];
                        end else begin
                           st_q   <= ST_CHAN;
                           pull_q <= 1'b0;
                        end
                     end
                     ST_CHAN: begin
                        st_q   <= ST_WDATA;
                        pull_q <= 1'b0;
                     end
                     ST_RDATA: begin
                        if (mack_q) begin
                           txreg_q <= rd_sample[BYTE_W-2:0];
                           pull_q  <= ~rd_sample[BYTE_W-1];
                        end else begin
                           st_q   <= ST_IDLE;
                           pull_q <= 1'b0;
                        end
                     end
                     default: pull_q <= 1'b0;
                  endcase
               end else if (st_q == ST_RDATA && bitcnt_q != '0) begin
                  txreg_q <= {txreg_q[BYTE_W-3:0], 1'b0};
                  pull_q  <= ~txreg_q[BYTE_W-2];
               end
            end
         end
      end
   end

   assign sda_pull = pull_q;

   // R1
   // pull-down may only begin on a clock that saw SCL fall
   sda_rise_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pull_q) |-> $past(scl_fall));

   // R8
   // an idle link never holds the line low
   idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_IDLE) |-> !pull_q);

endmodule

// File: rtl/i2cx_sink.sv
module i2cx_sink
   import i2cx_pkg::*;
#(
   parameter int DAC_CH_MAX = 8,
   parameter int DAC_CH_MIN = 4,
   parameter int DAC_W      = 8,
   parameter int PORT_W     = 8,
   parameter int NARROW_W   = 4
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        narrow,
   input  logic [PORT_W-1:0]           port_mask,
   input  logic                        chan_ev,
   input  logic                        data_ev,
   input  logic                        read_begin,
   input  logic                        xfer_end,
   input  logic [BYTE_W-1:0]           byte_val,
   output logic [PORT_W-1:0]           port_out,
   output logic [PORT_W-1:0]           port_oe,
   output logic [DAC_CH_MAX*DAC_W-1:0] dac_flat
);

   localparam logic [3:0] CNT_WIDE = 4'(DAC_CH_MAX);
   localparam logic [3:0] CNT_SLIM = 4'(DAC_CH_MIN);

   wr_tgt_e          tgt_q;
   logic [3:0]       sel_q;
   logic [3:0]       cnt_now;
   logic [3:0]       nib;
   logic             port_wr;
   logic [PORT_W-1:0] out_q, oe_q;

   assign cnt_now = narrow ? CNT_WIDE : CNT_SLIM;
   assign nib     = byte_val[3:0];
   assign port_wr = data_ev && (tgt_q == TGT_PORT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tgt_q <= TGT_NONE;
         sel_q <= '0;
      end else if (xfer_end) begin
         tgt_q <= TGT_NONE;
      end else if (chan_ev) begin
         if (nib == SEL_STREAM) begin
            tgt_q <= TGT_PORT;
         end else if (nib != 4'd0 && nib <= cnt_now) begin
            tgt_q <= TGT_DAC;
            sel_q <= nib;
         end else begin
            tgt_q <= TGT_NONE;
         end
      end else if (data_ev && tgt_q == TGT_DAC) begin
         tgt_q <= TGT_NONE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q <= '0;
         oe_q  <= '0;
      end else if (port_wr) begin
         out_q <= byte_val[PORT_W-1:0] & port_mask;
         oe_q  <= port_mask;
      end else if (read_begin) begin
         oe_q <= '0;
      end
   end

   assign port_out = out_q;
   assign port_oe  = oe_q;

   for (genvar k = 0; k < DAC_CH_MAX; k++) begin : g_dac
      logic [DAC_W-1:0] code_q;
      logic             we;
      assign we = data_ev && (tgt_q == TGT_DAC) && (sel_q == 4'(k + 1));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)  code_q <= '0;
         else if (we) code_q <= byte_val[DAC_W-1:0];
      end
      assign dac_flat[k*DAC_W +: DAC_W] = code_q;
   end

   // R3
   // data bytes not aimed at a DAC channel leave the whole bank alone
   dac_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (data_ev && tgt_q != TGT_DAC) |=> $stable(dac_flat));

   // R5
   // port data moves only after a data byte event
   port_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(out_q) |-> $past(data_ev));

   // R6
   // slim port never drives its upper bits
   narrow_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (port_wr && narrow) |=> (out_q[PORT_W-1:NARROW_W] == '0));

   // R9
   // the port can only be re-enabled by a stream byte
   oe_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(oe_q) && oe_q != '0) |-> $past(port_wr));

endmodule

// File: rtl/i2cx_expander.sv
module i2cx_expander
   import i2cx_pkg::*;
#(
   parameter logic [3:0] ADDR_HI    = 4'b1001,
   parameter int         DAC_CH_MAX = 8,
   parameter int         DAC_CH_MIN = 4,
   parameter int         DAC_W      = 8,
   parameter int         PORT_W     = 8,
   parameter int         NARROW_W   = 4
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        scl_i,
   input  logic                        sda_i,
   input  logic [2:0]                  strap_i,
   input  logic [PORT_W-1:0]           port_in_i,
   output logic                        sda_pull_o,
   output logic [PORT_W-1:0]           port_out_o,
   output logic [PORT_W-1:0]           port_oe_o,
   output logic [DAC_CH_MAX*DAC_W-1:0] dac_code_o
);

   if (PORT_W > BYTE_W || PORT_W < 1) begin : g_bad_port
      $error("PORT_W must lie in 1..8");
   end
   if (NARROW_W >= PORT_W || NARROW_W < 1) begin : g_bad_narrow
      $error("NARROW_W must be below PORT_W");
   end
   if (DAC_CH_MAX > 14 || DAC_CH_MIN < 1 || DAC_CH_MIN > DAC_CH_MAX) begin : g_bad_ch
      $error("channel counts must satisfy 1 <= MIN <= MAX <= 14");
   end
   if (DAC_W > BYTE_W || DAC_W < 1) begin : g_bad_dac
      $error("DAC_W must lie in 1..8");
   end

   logic                scl_rise, scl_fall, start_det, stop_det;
   logic                chan_ev, data_ev, read_begin, xfer_end;
   logic [BYTE_W-1:0]   byte_val;
   logic [BYTE_W-1:0]   rd_sample;
   logic [PORT_W-1:0]   port_mask;
   logic                narrow;

   assign narrow = strap_i[2];

   for (genvar i = 0; i < BYTE_W; i++) begin : g_lane
      if (i < NARROW_W) begin : g_always
         assign port_mask[i] = 1'b1;
         assign rd_sample[i] = port_in_i[i];
      end else if (i < PORT_W) begin : g_wide_only
         assign port_mask[i] = ~narrow;
         assign rd_sample[i] = port_in_i[i] & ~narrow;
      end else begin : g_absent
         assign rd_sample[i] = 1'b0;
      end
   end

   i2cx_line_mon u_mon (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   i2cx_link u_link (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_rise   (scl_rise),
      .scl_fall   (scl_fall),
      .start_det  (start_det),
      .stop_det   (stop_det),
      .sda_i      (sda_i),
      .dev_addr   ({ADDR_HI, strap_i}),
      .rd_sample  (rd_sample),
      .sda_pull   (sda_pull_o),
      .chan_ev    (chan_ev),
      .data_ev    (data_ev),
      .read_begin (read_begin),
      .xfer_end   (xfer_end),
      .byte_val   (byte_val)
   );

   i2cx_sink #(
      .DAC_CH_MAX (DAC_CH_MAX),
      .DAC_CH_MIN (DAC_CH_MIN),
      .DAC_W      (DAC_W),
      .PORT_W     (PORT_W),
      .NARROW_W   (NARROW_W)
   ) u_sink (
      .clk        (clk),
      .rst_n      (rst_n),
      .narrow     (narrow),
      .port_mask  (port_mask),
      .chan_ev    (chan_ev),
      .data_ev    (data_ev),
      .read_begin (read_begin),
      .xfer_end   (xfer_end),
      .byte_val   (byte_val),
      .port_out   (port_out_o),
      .port_oe    (port_oe_o),
      .dac_flat   (dac_code_o)
   );

endmodule

// File: tb/i2cx_expander_tb.sv
module i2cx_expander_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        scl_m = 1'b1;
   logic        sda_m = 1'b1;
   logic [2:0]  strap = 3'b000;
   logic [7:0]  port_in = 8'h00;
   logic        sda_pull;
   logic [7:0]  port_out, port_oe;
   logic [63:0] dac;
   wire         sda_line = sda_m & ~sda_pull;

   always #5 clk = ~clk;

   i2cx_expander u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_i      (scl_m),
      .sda_i      (sda_line),
      .strap_i    (strap),
      .port_in_i  (port_in),
      .sda_pull_o (sda_pull),
      .port_out_o (port_out),
      .port_oe_o  (port_oe),
      .dac_code_o (dac)
   );

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 1'b0;
   logic [7:0]  pre_out, pre_oe, at_out, at_oe;
   logic [63:0] exp_dac = '0;

   // {strap, selector, data, expected channel (0 = none)}
   localparam logic [22:0] VEC [0:8] = '{
      {3'b000, 8'h01, 8'h5A, 4'd1},
      {3'b000, 8'hF4, 8'hC3, 4'd4},
      {3'b000, 8'h05, 8'h77, 4'd0},
      {3'b100, 8'h05, 8'h11, 4'd5},
      {3'b100, 8'h08, 8'h22, 4'd8},
      {3'b100, 8'h09, 8'h33, 4'd0},
      {3'b011, 8'h02, 8'hA0, 4'd2},
      {3'b100, 8'h00, 8'h44, 4'd0},
      {3'b000, 8'h0E, 8'h99, 4'd0}
   };

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_h();
      repeat (4) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; wait_h();
      scl_m = 1'b1; wait_h();
      sda_m = 1'b0; wait_h();
      scl_m = 1'b0; wait_h();
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; wait_h();
      scl_m = 1'b1; wait_h();
      sda_m = 1'b1; wait_h();
   endtask

   task automatic wr_byte(input logic [7:0] b, output logic ack);
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; wait_h();
         scl_m = 1'b1; wait_h();
         if (i == 0) begin
            pre_out = port_out;
            pre_oe  = port_oe;
         end
         scl_m = 1'b0;
      end
      sda_m = 1'b1; wait_h();
      at_out = port_out;
      at_oe  = port_oe;
      scl_m = 1'b1; wait_h();
      ack = ~sda_line;
      scl_m = 1'b0; wait_h();
   endtask

   task automatic rd_byte(input logic give_ack, output logic [7:0] v);
      sda_m = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         wait_h();
         scl_m = 1'b1; wait_h();
         v[i] = sda_line;
         scl_m = 1'b0;
      end
      sda_m = ~give_ack; wait_h();
      scl_m = 1'b1; wait_h();
      scl_m = 1'b0; wait_h();
      sda_m = 1'b1; wait_h();
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      summary();
   end

   initial begin
      logic a0, a1, a2, a3;
      logic [7:0] rv;
      int lows;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      wait_h();

      // R11 reset state
      chk("R11 sda", {63'b0, sda_pull}, 64'd0);
      chk("R11 oe", {56'b0, port_oe}, 64'd0);
      chk("R11 out", {56'b0, port_out}, 64'd0);
      chk("R11 dac", dac, 64'd0);

      // R1 foreign address ignored
      strap = 3'b000;
      bus_start();
      wr_byte(8'h9A, a0); wr_byte(8'h01, a1); wr_byte(8'hEE, a2);
      bus_stop();
      chk("R1 no ack", {63'b0, a0}, 64'd0);
      chk("R1 no change", dac, 64'd0);

      // R2 R3 table walk
      for (int i = 0; i < 9; i++) begin
         logic [22:0] v;
         v = VEC[i];
         strap = v[22:20];
         wait_h();
         bus_start();
         wr_byte({4'b1001, v[22:20], 1'b0}, a0);
         wr_byte(v[19:12], a1);
         wr_byte(v[11:4], a2);
         bus_stop();
         if (v[3:0] != 4'd0) exp_dac[(v[3:0]-1)*8 +: 8] = v[11:4];
         chk("R1 acks", {61'b0, a0, a1, a2}, 64'h7);
         chk("R2/R3 bank", dac, exp_dac);
      end
      chk("R3 port untouched", {48'b0, port_oe, port_out}, 64'd0);

      // R4 only first byte after a DAC select
      strap = 3'b000; wait_h();
      bus_start();
      wr_byte(8'h90, a0); wr_byte(8'h03, a1); wr_byte(8'h10, a2); wr_byte(8'h20, a3);
      bus_stop();
      exp_dac[23:16] = 8'h10;
      chk("R4 ack", {63'b0, a3}, 64'd1);
      chk("R4 first only", dac, exp_dac);

      // R5 wide stream, update at ACK
      bus_start();
      wr_byte(8'h90, a0); wr_byte(8'hFF, a1);
      wr_byte(8'hA5, a2);
      chk("R5 before ack", {56'b0, pre_out}, 64'h00);
      chk("R5 at ack", {48'b0, at_oe, at_out}, 64'hFFA5);
      wr_byte(8'h3C, a3);
      chk("R5 hold before ack", {56'b0, pre_out}, 64'hA5);
      chk("R5 second at ack", {56'b0, at_out}, 64'h3C);
      bus_stop();
      chk("R5 dac untouched", dac, exp_dac);

      // R6 slim stream
      strap = 3'b100; wait_h();
      bus_start();
      wr_byte(8'h98, a0); wr_byte(8'h0F, a1); wr_byte(8'hB7, a2);
      bus_stop();
      chk("R6 slim", {48'b0, port_oe, port_out}, 64'h0F07);

      // R7 R8 R9 wide read
      strap = 3'b000; port_in = 8'h96; wait_h();
      bus_start();
      wr_byte(8'h91, a0);
      chk("R9 oe before read ack", {56'b0, pre_oe}, 64'h0F);
      chk("R9 floated at ack", {56'b0, at_oe}, 64'h00);
      chk("R1 read ack", {63'b0, a0}, 64'd1);
      port_in = 8'h3C;
      rd_byte(1'b1, rv);
      chk("R7 first sample", {56'b0, rv}, 64'h96);
      port_in = 8'h55;
      rd_byte(1'b0, rv);
      chk("R7 second sample", {56'b0, rv}, 64'h3C);
      chk("R8 released", {63'b0, sda_pull}, 64'd0);
      lows = 0;
      for (int i = 0; i < 9; i++) begin
         wait_h(); scl_m = 1'b1; wait_h();
         if (!sda_line) lows++;
         scl_m = 1'b0;
      end
      chk("R8 silent after nack", 64'(lows), 64'd0);
      bus_stop();

      // R7 slim read
      strap = 3'b111; port_in = 8'hE9; wait_h();
      bus_start();
      wr_byte(8'h9F, a0);
      rd_byte(1'b0, rv);
      bus_stop();
      chk("R7 slim sample", {56'b0, rv}, 64'h09);

      // R9 stays floated through DAC write, re-enabled by stream byte
      bus_start();
      wr_byte(8'h9E, a0); wr_byte(8'h02, a1); wr_byte(8'h55, a2);
      bus_stop();
      exp_dac[15:8] = 8'h55;
      chk("R9 floated after dac", {56'b0, port_oe}, 64'h00);
      chk("R2 wide ch2", dac, exp_dac);
      bus_start();
      wr_byte(8'h9E, a0); wr_byte(8'hFF, a1); wr_byte(8'h5A, a2);
      bus_stop();
      chk("R9 pre stream oe", {56'b0, pre_oe}, 64'h00);
      chk("R9 stream oe", {48'b0, at_oe, at_out}, 64'h0F0A);

      // R10 repeated START ends stream
      strap = 3'b000; wait_h();
      bus_start();
      wr_byte(8'h90, a0); wr_byte(8'hFF, a1); wr_byte(8'h11, a2);
      bus_start();
      wr_byte(8'h90, a0); wr_byte(8'h01, a1); wr_byte(8'h66, a2);
      bus_stop();
      exp_dac[7:0] = 8'h66;
      chk("R10 port kept", {56'b0, port_out}, 64'h11);
      chk("R10 selector needed", dac, exp_dac);

      summary();
   end

endmodule